// File: doc/BRIEF.md
# Programmable Video Sync Generator

This block produces the beam position and the timing strobes of a raster display: a horizontal counter that steps once per colour clock, a vertical counter that steps once per line, horizontal and vertical sync, a composite sync and a blanking strobe. After reset it runs a fixed broadcast timing, NTSC-style by default or PAL-style on request. Its line length, frame length and each sync and blank window can also be handed over one by one to values that software programs, so that the same hardware can drive a flicker-free productivity monitor.

A single 16-bit mode word selects the timing source of each output independently. It also selects the polarity of each sync output, gates the blank output and chooses what drives the composite sync. The window and total inputs are plain levels that are sampled every clock. The block has no bus of its own and is driven by the register file around it.

Top module: `sg_sync_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, both counters read 0; with mode 0 the syncs are then inactive (high) and blank is low.
- R2: The horizontal counter increments each clock until it reaches or passes the effective line total, then returns to 0. At that edge the vertical counter increments, or returns to 0 if it has reached or passed the effective frame total.
- R3: With mode bit 8 clear, the frame total is 312 (313 lines) when bit 6 is 1 and 262 (263 lines) when bit 6 is 0. PAL lines always last 227 clocks. NTSC lines alternate 227, 228, 227, ... from reset, driven by a flag that flips at every line end.
- R4: Mode bit 12 set stops the NTSC alternation, so every fixed-timing line lasts 227 clocks.
- R5: Mode bit 8 set makes the line total the horizontal-total input (a line of that value plus one clocks) and the frame total the vertical-total input. It also selects the programmed horizontal blank window.
- R6: Raw horizontal sync is true while start <= hcount < stop. The window is the programmed one when mode bit 9 is set and the fixed window [18, 35) otherwise.
- R7: Raw vertical sync is true while start <= vcount < stop. The window is the programmed one when mode bit 10 is set and the fixed window [3, 6) otherwise.
- R8: Mode bits 1, 2 and 3 set the polarity of horizontal, vertical and composite sync. A set bit drives the raw value, a clear bit drives its inverse (active low).
- R9: Raw composite sync is the OR of a horizontal and a vertical window. These are the programmed sync windows when mode bit 5 is set and bit 7 is clear; otherwise they are the fixed windows. Bit 7 (dual sync) thus keeps the composite output on fixed timing while the separate syncs follow the program.
- R10: Blank is low while mode bit 4 is clear. When bit 4 is set, blank is high while the horizontal blank window holds (programmed under bit 8, fixed [15, 53) otherwise) or while vcount < 21.
- R11: The productivity profile (mode 0x0710, horizontal total 0x71, horizontal sync 0x0F to 0x19, horizontal blank 0x09 to 0x71, vertical total 0x242, vertical sync 0x15 to 0x1D) gives 114-clock lines and 579-line frames. Horizontal sync goes low at 0x0F and high at 0x19, and vertical sync goes low on line 0x15 and high on line 0x1D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Colour clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 16 | Mode word (bit use in R3 to R10) |
| htotal_i | input | HW | Programmed line total (length minus one) |
| hsync_start_i | input | HW | Programmed horizontal sync start |
| hsync_stop_i | input | HW | Programmed horizontal sync stop |
| hblank_start_i | input | HW | Programmed horizontal blank start |
| hblank_stop_i | input | HW | Programmed horizontal blank stop |
| vtotal_i | input | VW | Programmed frame total (lines minus one) |
| vsync_start_i | input | VW | Programmed vertical sync start line |
| vsync_stop_i | input | VW | Programmed vertical sync stop line |
| hcount_o | output | HW | Horizontal beam counter |
| vcount_o | output | VW | Vertical beam counter |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| csync_o | output | 1 | Composite sync |
| blank_o | output | 1 | Blanking strobe |

## Verification
The line end and the vertical step can fall in the same cycle as a sync or blank window edge. They can also meet a change of the mode word that swaps the totals under a running counter. The random phase places windows past the line total and lowers totals beneath the current counter, and directed phases switch from a short programmed line into fixed PAL or NTSC a few lines before the frame end. A cycle-by-cycle model in the bench, built from the requirements, judges every counter value and every output in each of these cycles.

// File: rtl/sg_pkg.sv
package sg_pkg;
    localparam int MODE_W = 16;

    // mode word bit positions
    localparam int MB_HSPOL   = 1;
    localparam int MB_VSPOL   = 2;
    localparam int MB_CSPOL   = 3;
    localparam int MB_BLANKEN = 4;
    localparam int MB_VARCS   = 5;
    localparam int MB_PAL     = 6;
    localparam int MB_DUAL    = 7;
    localparam int MB_VARBEAM = 8;
    localparam int MB_VARHS   = 9;
    localparam int MB_VARVS   = 10;
    localparam int MB_NOLONG  = 12;

    // one comparator per window kind on each axis
    typedef enum logic [1:0] {
        WIN_SYNC  = 2'd0,
        WIN_BLANK = 2'd1,
        WIN_CSYNC = 2'd2
    } win_kind_e;
    localparam int N_WIN = 3;
endpackage

// File: rtl/sg_window.sv
module sg_window #(
    parameter int W = 9
) (
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] start_i,
    input  logic [W-1:0] stop_i,
    output logic         active_o
);
    always_comb begin
        active_o = (cnt_i >= start_i) && (cnt_i < stop_i);
    end
endmodule

// File: rtl/sg_beam_ctr.sv
module sg_beam_ctr #(
    parameter int HW = 9,
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] htot_i,
    input  logic [VW-1:0] vtot_i,
    output logic [HW-1:0] h_o,
    output logic [VW-1:0] v_o,
    output logic          long_o
);
    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
        logic          lng;
    } beam_s;

    beam_s beam_d, beam_q;

    always_comb begin
        beam_d = beam_q;
        if (beam_q.h >= htot_i) begin
            beam_d.h   = '0;
            beam_d.lng = ~beam_q.lng;
            if (beam_q.v >= vtot_i) begin
                beam_d.v = '0;
            end else begin
                beam_d.v = beam_q.v + 1'b1;
            end
        end else begin
            beam_d.h = beam_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beam_q <= '0;
        end else begin
            beam_q <= beam_d;
        end
    end

    assign h_o    = beam_q.h;
    assign v_o    = beam_q.v;
    assign long_o = beam_q.lng;

    AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (h_o < htot_i) |=> (h_o == $past(h_o) + 1'b1)); // R2
    AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (h_o >= htot_i) |=> (h_o == '0)); // R2
    AST_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (h_o < htot_i) |=> $stable(v_o)); // R2
    AST_V_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (h_o >= htot_i && v_o < vtot_i) |=> (v_o == $past(v_o) + 1'b1)); // R2
    AST_V_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (h_o >= htot_i && v_o >= vtot_i) |=> (v_o == '0)); // R2
endmodule

// File: rtl/sg_timing_sel.sv
module sg_timing_sel
    import sg_pkg::*;
#(
    parameter int HW          = 9,
    parameter int VW          = 11,
    parameter int LINE_CLKS   = 227,
    parameter int PAL_LINES   = 313,
    parameter int NTSC_LINES  = 263,
    parameter int FIX_HS_ON   = 18,
    parameter int FIX_HS_OFF  = 35,
    parameter int FIX_HB_ON   = 15,
    parameter int FIX_HB_OFF  = 53,
    parameter int FIX_VS_ON   = 3,
    parameter int FIX_VS_OFF  = 6,
    parameter int FIX_VB_LINES = 21
) (
    input  logic [MODE_W-1:0] mode_i,
    input  logic              long_i,
    input  logic [HW-1:0]     htotal_i,
    input  logic [HW-1:0]     hs_start_i,
    input  logic [HW-1:0]     hs_stop_i,
    input  logic [HW-1:0]     hb_start_i,
    input  logic [HW-1:0]     hb_stop_i,
    input  logic [VW-1:0]     vtotal_i,
    input  logic [VW-1:0]     vs_start_i,
    input  logic [VW-1:0]     vs_stop_i,
    output logic [HW-1:0]     htot_o,
    output logic [VW-1:0]     vtot_o,
    output logic [HW-1:0]     h_start_o [N_WIN],
    output logic [HW-1:0]     h_stop_o  [N_WIN],
    output logic [VW-1:0]     v_start_o [N_WIN],
    output logic [VW-1:0]     v_stop_o  [N_WIN]
);
    localparam logic [HW-1:0] HTOT_SHORT = HW'(LINE_CLKS - 1);
    localparam logic [HW-1:0] HTOT_LONG  = HW'(LINE_CLKS);
    localparam logic [VW-1:0] VTOT_PAL   = VW'(PAL_LINES - 1);
    localparam logic [VW-1:0] VTOT_NTSC  = VW'(NTSC_LINES - 1);
    localparam logic [HW-1:0] HS_ON  = HW'(FIX_HS_ON);
    localparam logic [HW-1:0] HS_OFF = HW'(FIX_HS_OFF);
    localparam logic [HW-1:0] HB_ON  = HW'(FIX_HB_ON);
    localparam logic [HW-1:0] HB_OFF = HW'(FIX_HB_OFF);
    localparam logic [VW-1:0] VS_ON  = VW'(FIX_VS_ON);
    localparam logic [VW-1:0] VS_OFF = VW'(FIX_VS_OFF);
    localparam logic [VW-1:0] VB_END = VW'(FIX_VB_LINES);

    logic var_beam, var_hs, var_vs, prog_cs, alternate;
    logic unused_mode_bits;

    assign unused_mode_bits = ^{mode_i[3:0], mode_i[4], mode_i[11], mode_i[15:13]};

    always_comb begin
        var_beam  = mode_i[MB_VARBEAM];
        var_hs    = mode_i[MB_VARHS];
        var_vs    = mode_i[MB_VARVS];
        prog_cs   = mode_i[MB_VARCS] & ~mode_i[MB_DUAL];
        alternate = ~mode_i[MB_PAL] & ~mode_i[MB_NOLONG];

        // totals
        if (var_beam) begin
            htot_o = htotal_i;
            vtot_o = vtotal_i;
        end else begin
            htot_o = (alternate && long_i) ? HTOT_LONG : HTOT_SHORT;
            vtot_o = mode_i[MB_PAL] ? VTOT_PAL : VTOT_NTSC;
        end

        // sync windows
        h_start_o[int'(WIN_SYNC)] = var_hs ? hs_start_i : HS_ON;
        h_stop_o[int'(WIN_SYNC)]  = var_hs ? hs_stop_i  : HS_OFF;
        v_start_o[int'(WIN_SYNC)] = var_vs ? vs_start_i : VS_ON;
        v_stop_o[int'(WIN_SYNC)]  = var_vs ? vs_stop_i  : VS_OFF;

        // blank windows
        h_start_o[int'(WIN_BLANK)] = var_beam ? hb_start_i : HB_ON;
        h_stop_o[int'(WIN_BLANK)]  = var_beam ? hb_stop_i  : HB_OFF;
        v_start_o[int'(WIN_BLANK)] = '0;
        v_stop_o[int'(WIN_BLANK)]  = VB_END;

        // composite windows
        h_start_o[int'(WIN_CSYNC)] = prog_cs ? hs_start_i : HS_ON;
        h_stop_o[int'(WIN_CSYNC)]  = prog_cs ? hs_stop_i  : HS_OFF;
        v_start_o[int'(WIN_CSYNC)] = prog_cs ? vs_start_i : VS_ON;
        v_stop_o[int'(WIN_CSYNC)]  = prog_cs ? vs_stop_i  : VS_OFF;
    end
endmodule

// File: rtl/sg_sync_out.sv
module sg_sync_out
    import sg_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  logic [N_WIN-1:0]  h_act_i,
    input  logic [N_WIN-1:0]  v_act_i,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              csync_o,
    output logic              blank_o
);
    logic hs_raw, vs_raw, cs_raw, bl_raw;
    logic unused_mode_bits;

    assign unused_mode_bits = ^{mode_i[0], mode_i[15:5]};

    always_comb begin
        hs_raw = h_act_i[int'(WIN_SYNC)];
        vs_raw = v_act_i[int'(WIN_SYNC)];
        cs_raw = h_act_i[int'(WIN_CSYNC)] | v_act_i[int'(WIN_CSYNC)];
        bl_raw = h_act_i[int'(WIN_BLANK)] | v_act_i[int'(WIN_BLANK)];

        // a clear polarity bit inverts: active low
        hsync_o = hs_raw ~^ mode_i[MB_HSPOL];
        vsync_o = vs_raw ~^ mode_i[MB_VSPOL];
        csync_o = cs_raw ~^ mode_i[MB_CSPOL];
        blank_o = bl_raw & mode_i[MB_BLANKEN];
    end
endmodule

// File: rtl/sg_sync_gen.sv
module sg_sync_gen
    import sg_pkg::*;
#(
    parameter int HW           = 9,
    parameter int VW           = 11,
    parameter int LINE_CLKS    = 227,
    parameter int PAL_LINES    = 313,
    parameter int NTSC_LINES   = 263,
    parameter int FIX_HS_ON    = 18,
    parameter int FIX_HS_OFF   = 35,
    parameter int FIX_HB_ON    = 15,
    parameter int FIX_HB_OFF   = 53,
    parameter int FIX_VS_ON    = 3,
    parameter int FIX_VS_OFF   = 6,
    parameter int FIX_VB_LINES = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [15:0]   mode_i,
    input  logic [HW-1:0] htotal_i,
    input  logic [HW-1:0] hsync_start_i,
    input  logic [HW-1:0] hsync_stop_i,
    input  logic [HW-1:0] hblank_start_i,
    input  logic [HW-1:0] hblank_stop_i,
    input  logic [VW-1:0] vtotal_i,
    input  logic [VW-1:0] vsync_start_i,
    input  logic [VW-1:0] vsync_stop_i,
    output logic [HW-1:0] hcount_o,
    output logic [VW-1:0] vcount_o,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          csync_o,
    output logic          blank_o
);
    logic [HW-1:0]    htot, h_cnt;
    logic [VW-1:0]    vtot, v_cnt;
    logic             long_flag;
    logic [HW-1:0]    h_start [N_WIN];
    logic [HW-1:0]    h_stop  [N_WIN];
    logic [VW-1:0]    v_start [N_WIN];
    logic [VW-1:0]    v_stop  [N_WIN];
    logic [N_WIN-1:0] h_act, v_act;

    sg_timing_sel #(
        .HW(HW), .VW(VW),
        .LINE_CLKS(LINE_CLKS), .PAL_LINES(PAL_LINES), .NTSC_LINES(NTSC_LINES),
        .FIX_HS_ON(FIX_HS_ON), .FIX_HS_OFF(FIX_HS_OFF),
        .FIX_HB_ON(FIX_HB_ON), .FIX_HB_OFF(FIX_HB_OFF),
        .FIX_VS_ON(FIX_VS_ON), .FIX_VS_OFF(FIX_VS_OFF),
        .FIX_VB_LINES(FIX_VB_LINES)
    ) u_sel (
        .mode_i     (mode_i),
        .long_i     (long_flag),
        .htotal_i   (htotal_i),
        .hs_start_i (hsync_start_i),
        .hs_stop_i  (hsync_stop_i),
        .hb_start_i (hblank_start_i),
        .hb_stop_i  (hblank_stop_i),
        .vtotal_i   (vtotal_i),
        .vs_start_i (vsync_start_i),
        .vs_stop_i  (vsync_stop_i),
        .htot_o     (htot),
        .vtot_o     (vtot),
        .h_start_o  (h_start),
        .h_stop_o   (h_stop),
        .v_start_o  (v_start),
        .v_stop_o   (v_stop)
    );

    sg_beam_ctr #(.HW(HW), .VW(VW)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .htot_i (htot),
        .vtot_i (vtot),
        .h_o    (h_cnt),
        .v_o    (v_cnt),
        .long_o (long_flag)
    );

    for (genvar k = 0; k < N_WIN; k++) begin : g_win
        sg_window #(.W(HW)) u_hwin (
            .cnt_i    (h_cnt),
            .start_i  (h_start[k]),
            .stop_i   (h_stop[k]),
            .active_o (h_act[k])
        );
        sg_window #(.W(VW)) u_vwin (
            .cnt_i    (v_cnt),
            .start_i  (v_start[k]),
            .stop_i   (v_stop[k]),
            .active_o (v_act[k])
        );
    end

    sg_sync_out u_out (
        .mode_i  (mode_i),
        .h_act_i (h_act),
        .v_act_i (v_act),
        .hsync_o (hsync_o),
        .vsync_o (vsync_o),
        .csync_o (csync_o),
        .blank_o (blank_o)
    );

    assign hcount_o = h_cnt;
    assign vcount_o = v_cnt;
endmodule

// File: tb/sg_sync_gen_test.sv
module sg_sync_gen_test;
    localparam int HW = 9;
    localparam int VW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   mode = '0;
    logic [HW-1:0] htotal = '0, hss = '0, hse = '0, hbs = '0, hbe = '0;
    logic [VW-1:0] vtotal = '0, vss = '0, vse = '0;
    logic [HW-1:0] hcount;
    logic [VW-1:0] vcount;
    logic          hsync, vsync, csync, blank;

    int  errors = 0;
    int  checks = 0;
    int  mh = 0, mv = 0;
    bit  mlng = 0;
    bit  prod = 0;

    always #2 clk = ~clk;

    sg_sync_gen uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .htotal_i(htotal), .hsync_start_i(hss), .hsync_stop_i(hse),
        .hblank_start_i(hbs), .hblank_stop_i(hbe),
        .vtotal_i(vtotal), .vsync_start_i(vss), .vsync_stop_i(vse),
        .hcount_o(hcount), .vcount_o(vcount),
        .hsync_o(hsync), .vsync_o(vsync), .csync_o(csync), .blank_o(blank)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (model h=%0d v=%0d mode=%h)",
                     tag, act, exp, mh, mv, mode);
        end
    endtask

    function automatic bit inwin(int c, int a, int b);
        return (c >= a) && (c < b);
    endfunction

    function automatic int e_htot();
        if (mode[8]) return int'(htotal);
        if (mode[6] || mode[12]) return 226;
        return mlng ? 227 : 226;
    endfunction

    function automatic int e_vtot();
        if (mode[8]) return int'(vtotal);
        return mode[6] ? 312 : 262;
    endfunction

    function automatic bit pol(bit raw, bit p);
        return p ? raw : !raw;
    endfunction

    function automatic bit e_hs();
        bit r = mode[9] ? inwin(mh, hss, hse) : inwin(mh, 18, 35);
        return pol(r, mode[1]);
    endfunction

    function automatic bit e_vs();
        bit r = mode[10] ? inwin(mv, vss, vse) : inwin(mv, 3, 6);
        return pol(r, mode[2]);
    endfunction

    function automatic bit e_cs();
        bit p = mode[5] && !mode[7];
        bit rh = p ? inwin(mh, hss, hse) : inwin(mh, 18, 35);
        bit rv = p ? inwin(mv, vss, vse) : inwin(mv, 3, 6);
        return pol(rh || rv, mode[3]);
    endfunction

    function automatic bit e_bl();
        bit rh = mode[8] ? inwin(mh, hbs, hbe) : inwin(mh, 15, 53);
        return mode[4] && (rh || mv < 21);
    endfunction

    task automatic model_step();
        if (mh >= e_htot()) begin
            mh = 0;
            mlng = !mlng;
            mv = (mv >= e_vtot()) ? 0 : mv + 1;
        end else begin
            mh++;
        end
    endtask

    task automatic check_all(input string ctag);
        chk({ctag, " hcount"}, 16'(hcount), 16'(mh));
        chk({ctag, " vcount"}, 16'(vcount), 16'(mv));
        chk("R6/R8 hsync", 16'(hsync), 16'(e_hs()));
        chk("R7/R8 vsync", 16'(vsync), 16'(e_vs()));
        chk("R9 csync", 16'(csync), 16'(e_cs()));
        chk("R10 blank", 16'(blank), 16'(e_bl()));
        if (prod) begin
            if (mh == 8'h0E) chk("R11 hsync before start", 16'(hsync), 16'd1);
            if (mh == 8'h0F) chk("R11 hsync low at start", 16'(hsync), 16'd0);
            if (mh == 8'h18) chk("R11 hsync low before stop", 16'(hsync), 16'd0);
            if (mh == 8'h19) chk("R11 hsync high at stop", 16'(hsync), 16'd1);
            if (mv == 30 && mh == 8'h09) chk("R11 hblank start", 16'(blank), 16'd1);
            if (mv == 30 && mh == 8'h08) chk("R11 before hblank", 16'(blank), 16'd0);
            if (mh == 0 && mv == 8'h15) chk("R11 vsync low", 16'(vsync), 16'd0);
            if (mh == 0 && mv == 8'h1D) chk("R11 vsync high", 16'(vsync), 16'd1);
            if (mh == 8'h71 && mv == 12'h242) chk("R11 last cell v", 16'(vcount), 16'h242);
        end
    endtask

    task automatic run(input int n, input string ctag);
        for (int i = 0; i < n; i++) begin
            model_step();
            @(negedge clk);
            check_all(ctag);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 hcount in reset", 16'(hcount), 16'd0);
        chk("R1 vcount in reset", 16'(vcount), 16'd0);
        rst_n = 1'b1;
        mh = 0; mv = 0; mlng = 0;
    endtask

    task automatic climb(input int line);
        // fast short lines up to the given line
        mode = 16'h0100; htotal = 9; vtotal = 500;
        while (mv < line) run(1, "R5");
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        do_reset();
        chk("R1 hcount", 16'(hcount), 16'd0);
        chk("R1 vcount", 16'(vcount), 16'd0);
        chk("R1 hsync idle", 16'(hsync), 16'd1);
        chk("R1 vsync idle", 16'(vsync), 16'd1);
        chk("R1 csync idle", 16'(csync), 16'd1);
        chk("R1 blank off", 16'(blank), 16'd0);

        // legacy NTSC, alternating lines
        run(700, "R3");
        // alternation disabled
        mode = 16'h1010;
        run(700, "R4");

        // PAL frame end with polarities flipped and blank on
        climb(305);
        mode = 16'h005E;
        run(2300, "R3");

        // NTSC frame end
        climb(255);
        mode = 16'h0010;
        run(2200, "R3");

        // composite from programmed windows, then dual sync
        mode = 16'h0730; htotal = 40; vtotal = 12;
        hss = 4; hse = 12; hbs = 0; hbe = 8; vss = 2; vse = 4;
        run(700, "R9");
        mode = 16'h07B0;
        run(700, "R9");

        // productivity profile from a fresh reset, one full frame
        mode = 16'h0710; htotal = 9'h71; hss = 9'h0F; hse = 9'h19;
        hbs = 9'h09; hbe = 9'h71; vtotal = 11'h242; vss = 11'h15; vse = 11'h1D;
        do_reset();
        prod = 1;
        run(114 * 579 + 300, "R11");
        prod = 0;

        // random configurations
        for (int k = 0; k < 10; k++) begin
            int ht;
            ht = 16 + int'($urandom % 64);
            mode = 16'($urandom) & 16'h17FE;
            htotal = HW'(ht);
            vtotal = VW'(8 + $urandom % 32);
            hss = HW'($urandom % (ht + 4));
            hse = HW'($urandom % (ht + 4));
            hbs = HW'($urandom % (ht + 4));
            hbe = HW'($urandom % (ht + 4));
            vss = VW'($urandom % 40);
            vse = VW'($urandom % 40);
            run(2500, "R5");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule